// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block lets a processor repeat a block of instructions a fixed number of times with no branch instruction at the end of each pass. A setup command gives three values: how many passes to make, how many instructions the body holds, and the address of the first body instruction. The block then counts body instructions as they issue. When the last instruction of a pass issues and passes remain, it asks the program-counter logic, in that same cycle, to redirect fetch to the stored start address. When the last instruction of the final pass issues, it signals completion instead and leaves loop mode.

Two down-counters hold the state of the loop. The pass counter starts at the pass count and steps down once per wrap. The body counter starts at the body length, steps down once per issued instruction, and is reloaded with the body length on every wrap. A setup that gives zero passes or zero body length is flagged at load time so that the program-counter logic can skip the body. A low issue enable freezes both counters.

The controller is a two-state machine. Its states are IDLE (no loop active) and BODY (a loop is running). Its transitions are START (IDLE to BODY on a valid setup), SKIP (a zero setup, which ends in IDLE), WRAP (BODY to BODY at the end of a pass that is not the last), FINISH (BODY to IDLE at the end of the last pass), RESTART (BODY to BODY on a new valid setup) and CANCEL (BODY to IDLE on a new zero setup).

Top module: `zol_loop_ctrl`

## Requirements
- R1: After reset, in_loop, zero_skip, loop_back and loop_done are low and loop_target is 0.
- R2: A setup with nonzero pass count and nonzero body length sets in_loop high from the next cycle. From that cycle, loop_target holds the setup start address.
- R3: In a cycle where in_loop is high, issue_en is high, setup_valid is low, and the instruction is the last one of a pass with more passes left, loop_back is high in that same cycle. The body count then starts again at the full body length.
- R4: In a cycle where the last instruction of the final pass issues, loop_done is high in that same cycle and loop_back is low. in_loop is low from the next cycle.
- R5: A cycle with issue_en low advances no counter and raises neither loop_back nor loop_done. The number of further instructions before the next wrap or finish is unchanged.
- R6: A setup with pass count 0 or body length 0 raises zero_skip for exactly the following cycle. in_loop is low in that cycle, and no loop_back or loop_done follows.
- R7: A setup while a loop runs replaces the running loop. In the setup cycle, loop_back and loop_done stay low even if issue_en is high.
- R8: issue_en while no loop is active raises neither loop_back nor loop_done and leaves in_loop low.
- R9: With pass count 1, the loop finishes after the body count of issued instructions with no loop_back. With body length 1, every issued instruction except the final one raises loop_back. A pass count of 255 gives 254 wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Load a new loop this cycle |
| setup_passes | input | CNT_W | Number of passes through the body |
| setup_len | input | CNT_W | Number of instructions in the body |
| setup_start | input | ADDR_W | Address of the first body instruction |
| issue_en | input | 1 | One instruction issues this cycle |
| loop_back | output | 1 | Redirect fetch to loop_target (same cycle as issue) |
| loop_target | output | ADDR_W | Stored loop start address |
| loop_done | output | 1 | Last instruction of the final pass issues |
| in_loop | output | 1 | A loop is active |
| zero_skip | output | 1 | The previous setup had a zero count; skip the body |

## Verification
loop_back and loop_done depend on the inputs within the same cycle, so the bench checks them in the same cycle as the issue that causes them, after the inputs have settled and before the next rising edge. in_loop, zero_skip and loop_target are registered and change one edge after the setup or final issue. The scoreboard entry for a cycle therefore carries the registered values from the previous edge together with the combinational values for the current inputs. The driver applies inputs just after the falling edge, and the monitor compares all five outputs late in the low phase, so every value is checked in the cycle it is due.

// File: rtl/zol_pkg.sv
package zol_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } zol_state_e;

endpackage

// File: rtl/zol_down_counter.sv
module zol_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload,
    input  logic [W-1:0] reload_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         at_one
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (reload)
            cnt <= reload_val;
        else if (dec)
            cnt <= cnt - ONE;
    end

    assign at_one = (cnt == ONE);

endmodule

// File: rtl/zol_fsm.sv
module zol_fsm
    import zol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic setup_valid,
    input  logic setup_ok,
    input  logic issue_en,
    input  logic body_last,
    input  logic pass_last,
    output logic in_loop,
    output logic zero_skip,
    output logic loop_back,
    output logic loop_done
);

    zol_state_e state, state_nxt;
    logic       pass_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            zero_skip <= 1'b0;
        end else begin
            state     <= state_nxt;
            zero_skip <= setup_valid && !setup_ok;
        end
    end

    // next state: START, SKIP, WRAP, FINISH, RESTART, CANCEL
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (setup_valid && setup_ok)
                    state_nxt = ST_BODY;
            end
            ST_BODY: begin
                if (setup_valid)
                    state_nxt = setup_ok ? ST_BODY : ST_IDLE;
                else if (issue_en && body_last && pass_last)
                    state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_loop   = 1'b0;
        pass_end  = 1'b0;
        loop_back = 1'b0;
        loop_done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_BODY: begin
                in_loop   = 1'b1;
                pass_end  = issue_en && !setup_valid && body_last;
                loop_back = pass_end && !pass_last;
                loop_done = pass_end && pass_last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/zol_loop_ctrl.sv
module zol_loop_ctrl #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_valid,
    input  logic [CNT_W-1:0]  setup_passes,
    input  logic [CNT_W-1:0]  setup_len,
    input  logic [ADDR_W-1:0] setup_start,
    input  logic              issue_en,
    output logic              loop_back,
    output logic [ADDR_W-1:0] loop_target,
    output logic              loop_done,
    output logic              in_loop,
    output logic              zero_skip
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] body_len_q;
    logic [CNT_W-1:0] body_cnt, pass_cnt;
    logic             body_last, pass_last;
    logic             setup_ok;
    logic             body_dec;

    assign setup_ok = (setup_passes != CNT_ZERO) && (setup_len != CNT_ZERO);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            body_len_q  <= '0;
            loop_target <= '0;
        end else if (setup_valid) begin
            body_len_q  <= setup_len;
            loop_target <= setup_start;
        end
    end

    assign body_dec = in_loop && issue_en && !setup_valid && !body_last;

    zol_down_counter #(.W(CNT_W)) u_body_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (setup_valid),
        .load_val   (setup_len),
        .reload     (loop_back),
        .reload_val (body_len_q),
        .dec        (body_dec),
        .cnt        (body_cnt),
        .at_one     (body_last)
    );

    zol_down_counter #(.W(CNT_W)) u_pass_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (setup_valid),
        .load_val   (setup_passes),
        .reload     (1'b0),
        .reload_val (CNT_ZERO),
        .dec        (loop_back),
        .cnt        (pass_cnt),
        .at_one     (pass_last)
    );

    zol_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_valid (setup_valid),
        .setup_ok    (setup_ok),
        .issue_en    (issue_en),
        .body_last   (body_last),
        .pass_last   (pass_last),
        .in_loop     (in_loop),
        .zero_skip   (zero_skip),
        .loop_back   (loop_back),
        .loop_done   (loop_done)
    );

endmodule

module zol_loop_ctrl_chk #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              setup_valid,
    input logic [CNT_W-1:0]  setup_passes,
    input logic [CNT_W-1:0]  setup_len,
    input logic [ADDR_W-1:0] setup_start,
    input logic              issue_en,
    input logic              loop_back,
    input logic [ADDR_W-1:0] loop_target,
    input logic              loop_done,
    input logic              in_loop,
    input logic              zero_skip
);

    // R2
    start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && setup_passes != '0 && setup_len != '0)
            |=> (in_loop && loop_target == $past(setup_start)));

    // R3
    back_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_back |-> (in_loop && issue_en && !setup_valid));

    // R4
    done_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |=> !in_loop);

    // R4
    back_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loop_back && loop_done));

    // R5
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop && !issue_en && !setup_valid) |-> (!loop_back && !loop_done));

    // R5
    stall_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop && !issue_en && !setup_valid) |=> in_loop);

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && (setup_passes == '0 || setup_len == '0))
            |=> (zero_skip && !in_loop));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_loop |-> (!loop_back && !loop_done));

endmodule

bind zol_loop_ctrl zol_loop_ctrl_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/zol_loop_ctrl_tb.sv
module zol_loop_ctrl_tb;

    localparam int CW = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          setup_valid = 1'b0;
    logic [CW-1:0] setup_passes = '0;
    logic [CW-1:0] setup_len = '0;
    logic [AW-1:0] setup_start = '0;
    logic          issue_en = 1'b0;
    logic          loop_back, loop_done, in_loop, zero_skip;
    logic [AW-1:0] loop_target;

    always #10 clk = ~clk;

    zol_loop_ctrl #(.CNT_W(CW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid),
        .setup_passes(setup_passes), .setup_len(setup_len),
        .setup_start(setup_start), .issue_en(issue_en),
        .loop_back(loop_back), .loop_target(loop_target),
        .loop_done(loop_done), .in_loop(in_loop), .zero_skip(zero_skip)
    );

    typedef struct {
        logic          lb;
        logic          ld;
        logic          il;
        logic          zs;
        logic [AW-1:0] tg;
        string         req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    // bench-side model of the requirements
    logic          m_in = 0, m_zs = 0;
    logic [AW-1:0] m_tg = '0;
    int            m_pass = 0, m_body = 0, m_len = 0;

    task automatic cyc(input bit sv, input int np, input int nl,
                       input int a, input bit iss, input string req);
        exp_t e;
        bit   last;
        @(negedge clk);
        #1;
        setup_valid  = sv;
        setup_passes = CW'(np);
        setup_len    = CW'(nl);
        setup_start  = AW'(a);
        issue_en     = iss;
        last = !sv && m_in && iss && (m_body == 1);
        e.lb = last && (m_pass != 1);
        e.ld = last && (m_pass == 1);
        e.il = m_in; e.zs = m_zs; e.tg = m_tg; e.req = req;
        q.push_back(e);
        // advance model
        m_zs = 1'b0;
        if (sv) begin
            m_tg = AW'(a);
            if (np == 0 || nl == 0) begin
                m_in = 1'b0; m_zs = 1'b1;
            end else begin
                m_in = 1'b1; m_pass = np; m_body = nl; m_len = nl;
            end
        end else if (m_in && iss) begin
            if (m_body == 1) begin
                if (m_pass == 1) m_in = 1'b0;
                else begin m_pass = m_pass - 1; m_body = m_len; end
            end else m_body = m_body - 1;
        end
    endtask

    task automatic chk1(input string req, input string nm,
                        input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp_v);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        #8;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk1(e.req, "loop_back",   int'(loop_back),   int'(e.lb));
            chk1(e.req, "loop_done",   int'(loop_done),   int'(e.ld));
            chk1(e.req, "in_loop",     int'(in_loop),     int'(e.il));
            chk1(e.req, "zero_skip",   int'(zero_skip),   int'(e.zs));
            chk1(e.req, "loop_target", int'(loop_target), int'(e.tg));
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        cyc(0, 0, 0, 0, 0, "R1");
        // R8: issue with no loop
        cyc(0, 0, 0, 0, 1, "R8");
        cyc(0, 0, 0, 0, 1, "R8");
        // R2 / R3 / R4: 3 passes of 2
        cyc(1, 3, 2, 8'h40, 0, "R2");
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, "R3");
        cyc(0, 0, 0, 0, 1, "R4");
        cyc(0, 0, 0, 0, 0, "R4");
        // R5: stalls interleaved, 2 passes of 3
        cyc(1, 2, 3, 8'h11, 0, "R5");
        for (int i = 0; i < 6; i++) begin
            cyc(0, 0, 0, 0, 0, "R5");
            cyc(0, 0, 0, 0, 1, "R5");
        end
        cyc(0, 0, 0, 0, 0, "R5");
        // R9: one pass, body 4
        cyc(1, 1, 4, 8'h22, 1, "R9");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, "R9");
        // R9: body 1, 4 passes
        cyc(1, 4, 1, 8'h33, 0, "R9");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, "R9");
        // R9: 255 passes of 1
        cyc(1, 255, 1, 8'hFF, 0, "R9");
        for (int i = 0; i < 256; i++) cyc(0, 0, 0, 0, 1, "R9");
        // R6: zero passes, zero length
        cyc(1, 0, 5, 8'h55, 1, "R6");
        cyc(0, 0, 0, 0, 1, "R6");
        cyc(0, 0, 0, 0, 1, "R6");
        cyc(1, 6, 0, 8'h66, 0, "R6");
        cyc(0, 0, 0, 0, 1, "R6");
        // R7: override while running, with issue in setup cycle
        cyc(1, 5, 5, 8'h70, 0, "R7");
        cyc(0, 0, 0, 0, 1, "R7");
        cyc(0, 0, 0, 0, 1, "R7");
        cyc(1, 2, 1, 8'h71, 1, "R7");
        cyc(0, 0, 0, 0, 1, "R7");
        cyc(0, 0, 0, 0, 1, "R7");
        cyc(0, 0, 0, 0, 0, "R7");
        // R6 / R7: zero setup cancels running loop
        cyc(1, 3, 3, 8'h80, 0, "R6");
        cyc(0, 0, 0, 0, 1, "R6");
        cyc(1, 0, 0, 8'h81, 1, "R6");
        cyc(0, 0, 0, 0, 1, "R6");
        cyc(0, 0, 0, 0, 0, "R6");
        @(negedge clk); @(negedge clk);
        #9;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule